// File: doc/BRIEF.md
# Dual-Source Saturating Event Counter

This block keeps a 22-bit count inside a 32-bit register word. Two sources change the count. Hardware logic raises increment or decrement requests. A bus master also moves the count by accessing the register: each bus write adds a fixed step, and each bus read removes a different fixed step. The write carries no data into the count. The access itself is the event.

Each direction has its own step size and its own clamp limit. Increments stop at an upper ceiling and decrements stop at a lower floor. Two flag outputs show whether the count is in the high band or the low band. If several events arrive in the same cycle, a fixed priority picks exactly one of them, and the others are dropped.

The count sits in bits 21:0 of the register word and bits 31:22 always read as zero. Reads are combinational: the bus sees the current count in the same cycle as the read strobe, and the read's own decrement lands at the next clock edge.

Top module: `sat_ctr_field`

## Requirements
- R1: After a synchronous active-high reset, the count is 0. The read word holds the count in bits 21:0, and bits 31:22 always read 0.
- R2: A hardware increment request adds 2 and a hardware decrement request subtracts 7. When both hardware requests are high together, only the increment is applied.
- R3: A bus write strobe adds 3 to the count.
- R4: A bus read strobe subtracts 5. The read word in the strobe cycle shows the count before this decrement, and the new value appears after the next rising edge.
- R5: An increment never takes the count above 90. A step that would pass 90 leaves the count at 90.
- R6: A decrement never takes the count below 3. A step that would pass 3 leaves the count at 3, and a count already at or below 3 is left unchanged by a decrement.
- R7: Exactly one event is applied per cycle, chosen in this priority order: hardware request, then bus read, then bus write. Events that lose arbitration have no effect.
- R8: The high-band flag is 1 exactly while the count is 68 or more.
- R9: The low-band flag is 1 exactly while the count is 6 or less.
- R10: In a cycle with no event, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_inc | input | 1 | Hardware increment request |
| hw_dec | input | 1 | Hardware decrement request |
| sw_rd | input | 1 | Bus read strobe |
| sw_wr | input | 1 | Bus write strobe |
| sw_rdata | output | 32 | Register word; count in bits 21:0 |
| inc_flag | output | 1 | High-band flag (count >= 68) |
| dec_flag | output | 1 | Low-band flag (count <= 6) |

## Verification
The read word and both flags follow the stored count combinationally. Each event therefore shows on every output exactly one rising edge after the cycle in which its strobe was presented.

The bench drives each stimulus at a falling edge and compares the outputs against its own reference count before the following rising edge. It then advances the reference by the single winning event at that edge. Because of this, a read strobe is always compared against the count before the read's own decrement. Directed runs cover both limits and both flag boundaries, and a long mixed run with random overlapping strobes exercises the priority order.

// File: rtl/sat_ctr_pkg.sv
package sat_ctr_pkg;

    localparam int unsigned CTR_W       = 22;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned HW_UP_STEP  = 2;
    localparam int unsigned HW_DN_STEP  = 7;
    localparam int unsigned WR_UP_STEP  = 3;
    localparam int unsigned RD_DN_STEP  = 5;
    localparam int unsigned UP_CEIL     = 90;
    localparam int unsigned DN_FLOOR    = 3;
    localparam int unsigned HIGH_MARK   = 68;
    localparam int unsigned LOW_MARK    = 6;

    typedef enum logic [2:0] {
        EV_IDLE   = 3'd0,
        EV_HW_UP  = 3'd1,
        EV_HW_DN  = 3'd2,
        EV_BUS_RD = 3'd3,
        EV_BUS_WR = 3'd4
    } ctr_event_e;

    typedef struct packed {
        logic       active;
        logic       up;
        ctr_event_e src;
    } ctr_cmd_t;

endpackage

// File: rtl/sat_ctr_arbiter.sv
module sat_ctr_arbiter
    import sat_ctr_pkg::*;
(
    input  logic     hw_inc,
    input  logic     hw_dec,
    input  logic     sw_rd,
    input  logic     sw_wr,
    output ctr_cmd_t cmd
);
    // Fixed priority: hardware (increment before decrement), then bus read, then bus write.
    always_comb begin
        cmd = '{active: 1'b0, up: 1'b0, src: EV_IDLE};
        if (hw_inc) begin
            cmd = '{active: 1'b1, up: 1'b1, src: EV_HW_UP};
        end else if (hw_dec) begin
            cmd = '{active: 1'b1, up: 1'b0, src: EV_HW_DN};
        end else if (sw_rd) begin
            cmd = '{active: 1'b1, up: 1'b0, src: EV_BUS_RD};
        end else if (sw_wr) begin
            cmd = '{active: 1'b1, up: 1'b1, src: EV_BUS_WR};
        end
    end
endmodule

// File: rtl/sat_ctr_stepper.sv
module sat_ctr_stepper
    import sat_ctr_pkg::*;
#(
    parameter int unsigned W        = CTR_W,
    parameter int unsigned HW_UP    = HW_UP_STEP,
    parameter int unsigned HW_DN    = HW_DN_STEP,
    parameter int unsigned WR_UP    = WR_UP_STEP,
    parameter int unsigned RD_DN    = RD_DN_STEP,
    parameter int unsigned CEIL     = UP_CEIL,
    parameter int unsigned FLOOR    = DN_FLOOR
) (
    input  logic [W-1:0] count,
    input  ctr_cmd_t     cmd,
    output logic [W-1:0] count_nxt
);
    localparam logic [W-1:0] CEIL_V  = W'(CEIL);
    localparam logic [W-1:0] FLOOR_V = W'(FLOOR);

    logic [W-1:0] step;

    function automatic logic [W-1:0] add_clamp(input logic [W-1:0] c, input logic [W-1:0] s);
        logic [W:0] t;
        t = {1'b0, c} + {1'b0, s};
        if (c >= CEIL_V)          return c;
        else if (t > {1'b0, CEIL_V}) return CEIL_V;
        else                      return t[W-1:0];
    endfunction

    function automatic logic [W-1:0] sub_clamp(input logic [W-1:0] c, input logic [W-1:0] s);
        if (c <= FLOOR_V)          return c;
        else if ((c - FLOOR_V) < s) return FLOOR_V;
        else                       return c - s;
    endfunction

    always_comb begin
        unique case (cmd.src)
            EV_HW_UP:  step = W'(HW_UP);
            EV_HW_DN:  step = W'(HW_DN);
            EV_BUS_RD: step = W'(RD_DN);
            EV_BUS_WR: step = W'(WR_UP);
            default:   step = '0;
        endcase
    end

    always_comb begin
        if (!cmd.active)  count_nxt = count;
        else if (cmd.up)  count_nxt = add_clamp(count, step);
        else              count_nxt = sub_clamp(count, step);
    end
endmodule

// File: rtl/sat_ctr_flags.sv
module sat_ctr_flags
    import sat_ctr_pkg::*;
#(
    parameter int unsigned W    = CTR_W,
    parameter int unsigned HIGH = HIGH_MARK,
    parameter int unsigned LOW  = LOW_MARK
) (
    input  logic [W-1:0] count,
    output logic         high_band,
    output logic         low_band
);
    localparam logic [W-1:0] HIGH_V = W'(HIGH);
    localparam logic [W-1:0] LOW_V  = W'(LOW);

    always_comb begin
        high_band = (count >= HIGH_V);
        low_band  = (count <= LOW_V);
    end
endmodule

// File: rtl/sat_ctr_field.sv
module sat_ctr_field
    import sat_ctr_pkg::*;
#(
    parameter int unsigned W      = CTR_W,
    parameter int unsigned REG_W  = WORD_W,
    parameter int unsigned HW_UP  = HW_UP_STEP,
    parameter int unsigned HW_DN  = HW_DN_STEP,
    parameter int unsigned WR_UP  = WR_UP_STEP,
    parameter int unsigned RD_DN  = RD_DN_STEP,
    parameter int unsigned CEIL   = UP_CEIL,
    parameter int unsigned FLOOR  = DN_FLOOR,
    parameter int unsigned HIGH   = HIGH_MARK,
    parameter int unsigned LOW    = LOW_MARK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_inc,
    input  logic             hw_dec,
    input  logic             sw_rd,
    input  logic             sw_wr,
    output logic [REG_W-1:0] sw_rdata,
    output logic             inc_flag,
    output logic             dec_flag
);
    localparam int unsigned PAD_W = REG_W - W;

    ctr_cmd_t     cmd;
    logic [W-1:0] count_q;
    logic [W-1:0] count_nxt;

    sat_ctr_arbiter u_arb (
        .hw_inc (hw_inc),
        .hw_dec (hw_dec),
        .sw_rd  (sw_rd),
        .sw_wr  (sw_wr),
        .cmd    (cmd)
    );

    sat_ctr_stepper #(
        .W(W), .HW_UP(HW_UP), .HW_DN(HW_DN), .WR_UP(WR_UP),
        .RD_DN(RD_DN), .CEIL(CEIL), .FLOOR(FLOOR)
    ) u_step (
        .count     (count_q),
        .cmd       (cmd),
        .count_nxt (count_nxt)
    );

    sat_ctr_flags #(.W(W), .HIGH(HIGH), .LOW(LOW)) u_flags (
        .count     (count_q),
        .high_band (inc_flag),
        .low_band  (dec_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_nxt;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign sw_rdata = {{PAD_W{1'b0}}, count_q};
        end else begin : g_nopad
            assign sw_rdata = count_q;
        end
    endgenerate
endmodule

// File: rtl/sat_ctr_field_chk.sv
module sat_ctr_field_chk #(
    parameter int unsigned W     = 22,
    parameter int unsigned REG_W = 32,
    parameter int unsigned HW_UP = 2,
    parameter int unsigned HW_DN = 7,
    parameter int unsigned WR_UP = 3,
    parameter int unsigned RD_DN = 5,
    parameter int unsigned CEIL  = 90,
    parameter int unsigned FLOOR = 3,
    parameter int unsigned HIGH  = 68,
    parameter int unsigned LOW   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             hw_inc,
    input logic             hw_dec,
    input logic             sw_rd,
    input logic             sw_wr,
    input logic [REG_W-1:0] sw_rdata,
    input logic             inc_flag,
    input logic             dec_flag
);
    int unsigned cnt;
    assign cnt = int'(sw_rdata[W-1:0]);

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        sw_rdata[REG_W-1:W] == '0);

    p_hw_up_r2: assert property (@(posedge clk) disable iff (rst)
        (hw_inc && cnt + HW_UP <= CEIL) |=> (cnt == $past(cnt) + HW_UP));

    p_hw_dn_r2: assert property (@(posedge clk) disable iff (rst)
        (!hw_inc && hw_dec && cnt >= FLOOR + HW_DN) |=> (cnt == $past(cnt) - HW_DN));

    p_wr_up_r3: assert property (@(posedge clk) disable iff (rst)
        (!hw_inc && !hw_dec && !sw_rd && sw_wr && cnt + WR_UP <= CEIL)
        |=> (cnt == $past(cnt) + WR_UP));

    p_rd_dn_r4: assert property (@(posedge clk) disable iff (rst)
        (!hw_inc && !hw_dec && sw_rd && cnt >= FLOOR + RD_DN) |=> (cnt == $past(cnt) - RD_DN));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CEIL);

    p_floor_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!hw_inc && (hw_dec || sw_rd) && cnt <= FLOOR) |=> $stable(sw_rdata));

    p_high_flag_r8: assert property (@(posedge clk) disable iff (rst)
        inc_flag == (cnt >= HIGH));

    p_low_flag_r9: assert property (@(posedge clk) disable iff (rst)
        dec_flag == (cnt <= LOW));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!hw_inc && !hw_dec && !sw_rd && !sw_wr) |=> $stable(sw_rdata));
endmodule

bind sat_ctr_field sat_ctr_field_chk #(
    .W(W), .REG_W(REG_W), .HW_UP(HW_UP), .HW_DN(HW_DN), .WR_UP(WR_UP),
    .RD_DN(RD_DN), .CEIL(CEIL), .FLOOR(FLOOR), .HIGH(HIGH), .LOW(LOW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hw_inc   (hw_inc),
    .hw_dec   (hw_dec),
    .sw_rd    (sw_rd),
    .sw_wr    (sw_wr),
    .sw_rdata (sw_rdata),
    .inc_flag (inc_flag),
    .dec_flag (dec_flag)
);

// File: tb/sat_ctr_field_tb.sv
`timescale 1ns/1ps
module sat_ctr_field_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_inc = 1'b0, hw_dec = 1'b0, sw_rd = 1'b0, sw_wr = 1'b0;
    logic [31:0] sw_rdata;
    logic        inc_flag, dec_flag;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sat_ctr_field u_dut (
        .clk(clk), .rst(rst), .hw_inc(hw_inc), .hw_dec(hw_dec),
        .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_rdata(sw_rdata),
        .inc_flag(inc_flag), .dec_flag(dec_flag)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int up_by(input int c, input int s);
        if (c >= 90) return c;
        return (c + s > 90) ? 90 : c + s;
    endfunction

    function automatic int down_by(input int c, input int s);
        if (c <= 3) return c;
        return (c - s < 3) ? 3 : c - s;
    endfunction

    // Drive one cycle of strobes, compare outputs before the edge, advance model at the edge.
    task automatic cycle(input bit hi, input bit hd, input bit rd, input bit wr, input string tag);
        hw_inc = hi; hw_dec = hd; sw_rd = rd; sw_wr = wr;
        #1;
        check({tag, " count"}, sw_rdata[21:0], model);
        check("R1 upper bits", sw_rdata[31:22], 0);
        check("R8 high flag", inc_flag, model >= 68);
        check("R9 low flag", dec_flag, model <= 6);
        @(posedge clk);
        if (hi)      model = up_by(model, 2);
        else if (hd) model = down_by(model, 7);
        else if (rd) model = down_by(model, 5);
        else if (wr) model = up_by(model, 3);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset count", sw_rdata, 0);
        check("R9 low flag at reset", dec_flag, 1);
        check("R8 high flag at reset", inc_flag, 0);
        @(negedge clk);
        rst = 1'b0;
        cycle(0, 0, 0, 0, "R10 idle");
        cycle(0, 1, 0, 0, "R6 dec below floor");
        cycle(0, 0, 1, 0, "R6 read below floor");
        // Climb through the high mark to the ceiling with hardware increments.
        for (int i = 0; i < 50; i++) cycle(1, 0, 0, 0, "R2 R5 hw inc");
        cycle(0, 0, 0, 1, "R5 write at ceiling");
        cycle(0, 0, 0, 0, "R5 ceiling held");
        cycle(0, 0, 1, 0, "R4 read pre-value");
        cycle(0, 0, 0, 0, "R4 read post-value");
        cycle(1, 1, 0, 0, "R2 both hw");
        cycle(0, 1, 1, 1, "R7 hw over bus");
        cycle(0, 0, 1, 1, "R7 read over write");
        for (int i = 0; i < 14; i++) cycle(0, 1, 0, 0, "R2 R6 hw dec");
        for (int i = 0; i < 30; i++) cycle(0, 0, 0, 1, "R3 bus write");
        for (int i = 0; i < 25; i++) cycle(0, 0, 1, 0, "R4 R6 bus read");
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            cycle(r[0] & r[1], r[2] & ~r[3], r[3], r[1] | r[2], "R7 mixed");
        end
        cycle(0, 0, 0, 0, "R10 final");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule